// File: doc/BRIEF.md
# User-Bank Mapping Supervisor Controller

This glue block sits next to a 16-bit-extended 6502-family processor. That processor multiplexes the top byte of its 24-bit address onto the data bus during the low half of phi2. The block captures that bank byte and follows the privilege state by watching bus status. It then drives the upper eight bits of the physical address. Supervisor accesses keep the processor's bank. User accesses are forced into one software-chosen 64K bank, so user stack, direct-page and vector-free code can never leave it.

Privilege follows interrupts. The first cycle of every vector fetch raises a nesting count and selects supervisor. Each fetched return-from-interrupt opcode lowers the count, and user mode resumes when the count reaches zero. The single user-bank register sits in a 256-byte register page. Only supervisor writes can load it. A user write into that page raises an abort request for the whole bus cycle.

The block runs on a clock at twice the bus rate. The `ph2_i` input tells which half of the bus cycle the current clock belongs to: 0 for the phi2-low half, 1 for the phi2-high half. The clock edge that ends a low half stands for the rising edge of phi2, and the edge that ends a high half stands for the falling edge.

Top module: `priv_bank_map`

## Requirements
- R1: After reset the block is in supervisor mode with a nesting count of zero and a user bank of zero.
- R2: In supervisor mode, during the phi2-high half, `addr_o[23:16]` equals the `data_i` value captured at the phi2 rising edge, and `addr_o[15:0]` equals `addr_i`.
- R3: In user mode, during the phi2-high half, `addr_o[23:16]` equals the user bank register for every access, whatever bank byte the processor drove.
- R4: A bus cycle with `vpb_i` high is mapped as supervisor, and the block is in supervisor mode after it.
- R5: A run of consecutive vector-pull cycles raises the nesting count by exactly one. The count saturates at 2^CNT_W-1.
- R6: A return fetch is a cycle with `vda_i`, `vpa_i` and `rw_i` all high, `vpb_i` low, and opcode 0x40 on `data_i` in the phi2-high half. It lowers the count, saturating at zero, and user mode follows when the resulting count is zero. The same byte without `vda_i` and `vpa_i` both high has no effect.
- R7: The user bank register loads from `data_i` in the phi2-high half of a supervisor write (`vda_i` high, `rw_i` low) to address `{REG_PAGE, UB_OFS}`, which is 0xDF00 by default.
- R8: A user-mode write with `vda_i` high to page `REG_PAGE` drives `abort_o` high in both halves of that bus cycle and leaves the user bank register unchanged.
- R9: `abort_o` stays low for user reads, for supervisor writes, and for writes outside the register page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the bus rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ph2_i | input | 1 | Bus half: 0 for the phi2-low half, 1 for the phi2-high half |
| data_i | input | 8 | Data bus: bank byte in the low half, opcode or write data in the high half |
| addr_i | input | 16 | Processor address bits 15..0 |
| rw_i | input | 1 | 1 for read, 0 for write |
| vda_i | input | 1 | Valid data address |
| vpa_i | input | 1 | Valid program address |
| vpb_i | input | 1 | Vector pull, active high |
| addr_o | output | 24 | Physical address |
| abort_o | output | 1 | Abort request for a privilege violation |

## Verification
The bench first walks all 256 bank bytes, once in supervisor mode and once in user mode. This separates pass-through from substitution and catches stuck or swapped bank bits. Directed sequences then cover several cases: nested vector pulls against single ones, a count that saturates against the return fetch that finally reaches zero, a return fetch at zero, and a 0x40 byte read without opcode status. Each one pins down a different piece of the counter. A long pseudo-random mix of bank bytes, register-page writes, vector pulls and returns is compared on every half-cycle with an arithmetic model. That comparison separates abort cases by mode, direction and page.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  typedef enum logic {MODE_SUP = 1'b0, MODE_USR = 1'b1} mode_e;

  typedef struct packed {
    logic vda;
    logic vpa;
    logic vpb;
    logic rw;
  } bus_stat_t;
endpackage

// File: rtl/pbm_bank_latch.sv
module pbm_bank_latch #(
  parameter int BANK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ph2_i,
  input  logic [BANK_W-1:0] data_i,
  output logic [BANK_W-1:0] bank_o
);
  // the edge that closes the low half stands for the phi2 rising edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bank_o <= '0;
    else if (!ph2_i) bank_o <= data_i;
  end
endmodule

// File: rtl/pbm_bank_mux.sv
module pbm_bank_mux #(
  parameter int BANK_W = 8
) (
  input  logic              sup_i,
  input  logic [BANK_W-1:0] cpu_bank_i,
  input  logic [BANK_W-1:0] user_bank_i,
  output logic [BANK_W-1:0] bank_o
);
  for (genvar b = 0; b < BANK_W; b++) begin : g_bit
    assign bank_o[b] = sup_i ? cpu_bank_i[b] : user_bank_i[b];
  end
endmodule

// File: rtl/pbm_mode_track.sv
module pbm_mode_track
  import pbm_pkg::*;
#(
  parameter int         CNT_W  = 3,
  parameter logic [7:0] RTI_OP = 8'h40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ph2_i,
  input  bus_stat_t        stat_i,
  input  logic [7:0]       data_i,
  output mode_e            mode_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             vp_prev;
  logic             vp_start;
  logic             rti_fetch;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] cnt_dec;

  assign vp_start  = stat_i.vpb & ~vp_prev;
  assign rti_fetch = stat_i.vda & stat_i.vpa & stat_i.rw & ~stat_i.vpb
                   & (data_i == RTI_OP);
  assign cnt_inc   = (cnt_o == CNT_MAX) ? CNT_MAX : cnt_o + 1'b1;
  assign cnt_dec   = (cnt_o == '0) ? '0 : cnt_o - 1'b1;

  // commit on the edge that closes the high half (phi2 falling)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vp_prev <= 1'b0;
      cnt_o   <= '0;
      mode_o  <= MODE_SUP;
    end else if (ph2_i) begin
      vp_prev <= stat_i.vpb;
      if (vp_start) begin
        cnt_o  <= cnt_inc;
        mode_o <= MODE_SUP;
      end else if (stat_i.vpb) begin
        mode_o <= MODE_SUP;
      end else if (rti_fetch) begin
        cnt_o  <= cnt_dec;
        mode_o <= (cnt_dec == '0) ? MODE_USR : MODE_SUP;
      end
    end
  end
endmodule

// File: rtl/pbm_reg_guard.sv
module pbm_reg_guard #(
  parameter logic [7:0] REG_PAGE = 8'hDF,
  parameter logic [7:0] UB_OFS   = 8'h00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ph2_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  data_i,
  input  logic        rw_i,
  input  logic        vda_i,
  input  logic        user_now_i,
  output logic [7:0]  ubank_o,
  output logic        abort_o
);
  logic page_wr;
  logic load;

  assign page_wr = vda_i & ~rw_i & (addr_i[15:8] == REG_PAGE);
  // held for the whole bus cycle so it is stable ahead of phi2 rising
  assign abort_o = page_wr & user_now_i;
  assign load    = ph2_i & page_wr & ~user_now_i & (addr_i[7:0] == UB_OFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ubank_o <= '0;
    else if (load) ubank_o <= data_i;
  end
endmodule

// File: rtl/priv_bank_map.sv
module priv_bank_map
  import pbm_pkg::*;
#(
  parameter int         CNT_W    = 3,
  parameter logic [7:0] REG_PAGE = 8'hDF,
  parameter logic [7:0] UB_OFS   = 8'h00,
  parameter logic [7:0] RTI_OP   = 8'h40
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ph2_i,
  input  logic [7:0]  data_i,
  input  logic [15:0] addr_i,
  input  logic        rw_i,
  input  logic        vda_i,
  input  logic        vpa_i,
  input  logic        vpb_i,
  output logic [23:0] addr_o,
  output logic        abort_o
);
  localparam int BANK_W = 8;

  bus_stat_t        stat;
  mode_e            mode;
  logic             user_q;
  logic             user_now;
  logic [CNT_W-1:0] nest_cnt;
  logic [7:0]       bank_lat;
  logic [7:0]       ubank;
  logic [7:0]       bank_out;

  assign stat     = '{vda: vda_i, vpa: vpa_i, vpb: vpb_i, rw: rw_i};
  assign user_q   = (mode == MODE_USR);
  assign user_now = user_q & ~vpb_i;

  pbm_bank_latch #(.BANK_W(BANK_W)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ph2_i (ph2_i),
    .data_i(data_i),
    .bank_o(bank_lat)
  );

  pbm_mode_track #(.CNT_W(CNT_W), .RTI_OP(RTI_OP)) u_mode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ph2_i (ph2_i),
    .stat_i(stat),
    .data_i(data_i),
    .mode_o(mode),
    .cnt_o (nest_cnt)
  );

  pbm_reg_guard #(.REG_PAGE(REG_PAGE), .UB_OFS(UB_OFS)) u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ph2_i     (ph2_i),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .rw_i      (rw_i),
    .vda_i     (vda_i),
    .user_now_i(user_now),
    .ubank_o   (ubank),
    .abort_o   (abort_o)
  );

  pbm_bank_mux #(.BANK_W(BANK_W)) u_mux (
    .sup_i      (~user_now),
    .cpu_bank_i (bank_lat),
    .user_bank_i(ubank),
    .bank_o     (bank_out)
  );

  assign addr_o = {bank_out, addr_i};
endmodule

// File: rtl/priv_bank_map_chk.sv
module priv_bank_map_chk #(
  parameter int         CNT_W    = 3,
  parameter logic [7:0] REG_PAGE = 8'hDF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ph2_i,
  input logic [7:0]       data_i,
  input logic [15:0]      addr_i,
  input logic             rw_i,
  input logic             vpb_i,
  input logic [23:0]      addr_o,
  input logic             abort_o,
  input logic             user_q,
  input logic [CNT_W-1:0] nest_cnt,
  input logic [7:0]       ubank
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  a_r2_pass_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && ph2_i && $past(!ph2_i) && (!user_q || vpb_i))
      |-> (addr_o[23:16] == $past(data_i)));

  a_r3_user_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph2_i && user_q && !vpb_i) |-> (addr_o[23:16] == ubank));

  a_r4_vp_super: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph2_i && vpb_i) |=> !user_q);

  a_r5_cnt_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph2_i && vpb_i && nest_cnt == CNT_MAX) |=> (nest_cnt == CNT_MAX));

  a_r6_user_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_q |-> (nest_cnt == '0));

  a_r8_abort_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (user_q && !vpb_i && !rw_i && addr_i[15:8] == REG_PAGE));

  a_r8_keep_ubank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && ph2_i && abort_o) |=> $stable(ubank));
endmodule

bind priv_bank_map priv_bank_map_chk #(.CNT_W(CNT_W), .REG_PAGE(REG_PAGE)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ph2_i   (ph2_i),
  .data_i  (data_i),
  .addr_i  (addr_i),
  .rw_i    (rw_i),
  .vpb_i   (vpb_i),
  .addr_o  (addr_o),
  .abort_o (abort_o),
  .user_q  (user_q),
  .nest_cnt(nest_cnt),
  .ubank   (ubank)
);

// File: tb/priv_bank_map_bench.sv
`timescale 1ns/1ps
module priv_bank_map_bench;
  localparam int         CNT_W    = 3;
  localparam int         CMAX     = (1 << CNT_W) - 1;
  localparam logic [7:0] REG_PAGE = 8'hDF;
  localparam logic [7:0] UB_OFS   = 8'h00;
  localparam logic [7:0] RTI      = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ph2 = 1'b0;
  logic [7:0]  data = '0;
  logic [15:0] addr = '0;
  logic        rw = 1'b1, vda = 1'b0, vpa = 1'b0, vpb = 1'b0;
  logic [23:0] addr_o;
  logic        abort_o;

  always #2.5 clk = ~clk;

  priv_bank_map #(.CNT_W(CNT_W), .REG_PAGE(REG_PAGE), .UB_OFS(UB_OFS), .RTI_OP(RTI))
  u_priv_bank_map (
    .clk_i(clk), .rst_ni(rst_n), .ph2_i(ph2), .data_i(data), .addr_i(addr),
    .rw_i(rw), .vda_i(vda), .vpa_i(vpa), .vpb_i(vpb),
    .addr_o(addr_o), .abort_o(abort_o)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference state
  bit       m_user = 0;
  int       m_cnt  = 0;
  bit       m_vpp  = 0;
  bit [7:0] m_ub   = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, logic [7:0] bank, logic [15:0] a, logic r,
                     logic da, logic pa, logic vp, logic [7:0] dhi);
    bit       sup_now;
    bit       ab;
    bit [7:0] eb;
    sup_now = !m_user || vp;
    eb      = sup_now ? bank : m_ub;
    ab      = !sup_now && da && !r && (a[15:8] == REG_PAGE);
    @(negedge clk);
    ph2 = 1'b0; data = bank; addr = a; rw = r; vda = da; vpa = pa; vpb = vp;
    #1;
    chk(ab ? "R8" : "R9", {31'd0, abort_o}, {31'd0, ab});
    @(negedge clk);
    ph2 = 1'b1; data = dhi;
    #1;
    chk(tag, {8'd0, addr_o}, {8'd0, eb, a});
    chk(ab ? "R8" : "R9", {31'd0, abort_o}, {31'd0, ab});
    if (sup_now && da && !r && a == {REG_PAGE, UB_OFS}) m_ub = dhi;
    if (vp && !m_vpp) begin
      m_cnt  = (m_cnt == CMAX) ? CMAX : m_cnt + 1;
      m_user = 0;
    end else if (vp) begin
      m_user = 0;
    end else if (da && pa && r && dhi == RTI) begin
      m_cnt  = (m_cnt == 0) ? 0 : m_cnt - 1;
      m_user = (m_cnt == 0);
    end
    m_vpp = vp;
  endtask

  task automatic rd(string tag, logic [7:0] bank, logic [15:0] a);
    cyc(tag, bank, a, 1'b1, 1'b1, 1'b0, 1'b0, 8'h11);
  endtask
  task automatic wr(string tag, logic [7:0] bank, logic [15:0] a, logic [7:0] d);
    cyc(tag, bank, a, 1'b0, 1'b1, 1'b0, 1'b0, d);
  endtask
  task automatic rti(string tag);
    cyc(tag, 8'h00, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b0, RTI);
  endtask
  task automatic vpull(string tag);
    cyc(tag, 8'h00, 16'hFFEA, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    cyc(tag, 8'h00, 16'hFFEB, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: supervisor after reset
    rd("R1", 8'h5A, 16'h1234);
    // R2: every bank byte passes in supervisor mode
    for (int b = 0; b < 256; b++) rd("R2", b[7:0], {b[7:0] ^ 8'hC3, b[7:0]});
    // R6: return at count zero enters user; R1: user bank resets to zero
    rti("R6");
    rd("R1", 8'h77, 16'h4000);
    // R4: vector pull passes bank and ends in supervisor
    cyc("R4", 8'h9C, 16'hFFEE, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    cyc("R4", 8'h9C, 16'hFFEF, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    rd("R4", 8'h3E, 16'h0100);
    // R7: load user bank
    wr("R7", 8'h00, {REG_PAGE, UB_OFS}, 8'hA5);
    wr("R9", 8'h00, {REG_PAGE, 8'h01}, 8'h66);
    rti("R6");
    // R3: every bank byte substituted in user mode
    for (int b = 0; b < 256; b++) rd("R3", b[7:0], {b[7:0], 8'h3C});
    cyc("R3", 8'h12, 16'h01F0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h99);
    // R8: user write to register page aborts and leaves bank alone
    wr("R8", 8'h00, {REG_PAGE, UB_OFS}, 8'h13);
    rd("R8", 8'h00, 16'h2000);
    rd("R9", 8'h00, {REG_PAGE, UB_OFS});
    // R6: 0x40 read without opcode status is ignored
    vpull("R4");
    cyc("R6", 8'h04, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b0, RTI);
    cyc("R6", 8'h05, 16'h8000, 1'b1, 1'b0, 1'b1, 1'b0, RTI);
    rd("R6", 8'h06, 16'h0200);
    // R6: nesting of two
    vpull("R5");
    rti("R6");
    rd("R6", 8'h21, 16'h0300);
    rti("R6");
    rd("R6", 8'h22, 16'h0300);
    // R5: saturation, separated pulls
    for (int k = 0; k < CMAX + 2; k++) begin
      vpull("R5");
      rd("R5", 8'h30, 16'h0400);
    end
    for (int k = 0; k < CMAX - 1; k++) begin
      rti("R5");
      rd("R5", 8'h31, 16'h0500);
    end
    rti("R5");
    rd("R5", 8'h32, 16'h0500);
    rti("R6");
    rd("R6", 8'h33, 16'h0500);
    // mixed sweep against the model
    r = 32'h1ACE_B00C;
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      logic [7:0]  dh;
      r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
      a  = (r[18:16] == 3'd0) ? {REG_PAGE, (r[19] ? UB_OFS : r[27:20])} : r[31:16];
      dh = (r[25:23] < 3'd3) ? RTI : r[31:24];
      cyc(m_user ? "R3" : "R2", r[7:0], a, r[12], r[13] | r[14], r[15],
          (r[22:20] == 3'd0), dh);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule